// File: doc/BRIEF.md
# Multi-slot hash bucket update engine

This block carries out one hash-table operation per clock cycle on a single bucket. A bucket has a fixed number of slots. Each slot stores a key, a value and a valid flag. Alongside the request (an opcode, a key and a value), the caller presents the bucket contents that were read from table memory. The engine compares the request key with every occupied slot and decides which slot, if any, the operation changes. It then returns the complete bucket image to be written back, the search result, and status flags.

Hashing, the memory controller and hazard forwarding all sit outside the block. The engine drives a set of forwarding outputs so that a neighbouring forwarding unit can capture the post-operation state of each request. The pipeline has a fixed depth of two registers. It never stalls, so a new request can enter on every cycle.

Top module: `bucket_update_engine`

## Requirements
- R1: A slot matches only when its valid flag is 1 and its stored key equals `in_key`. Slot i sits at bits `[i*KEY_W +: KEY_W]` of `rd_keys`, at `[i*VAL_W +: VAL_W]` of `rd_vals`, and at bit i of `rd_valid`. When several slots match, the lowest-indexed one is used.
- R2: Search (opcode 2'b00). On a match, `hit` is 1 and `srch_val` carries the matching slot's value. On a miss, `hit` is 0 and `srch_val` is 0. A search never changes the bucket, and `wb_en` stays 0.
- R3: Insert (opcode 2'b01) with a match replaces the value of the matching slot, keeps its key and valid flag, and raises `wb_en`.
- R4: Insert with no match writes the key and value into the lowest-indexed slot whose valid flag is 0, sets that flag, and raises `wb_en`.
- R5: Insert with no match into a bucket whose valid flags are all 1 raises `full`. The bucket is returned unchanged and `wb_en` stays 0.
- R6: Delete (opcode 2'b10) with a match clears the valid flag of the matching slot and raises `wb_en`. Delete with no match leaves the bucket unchanged and keeps `wb_en` at 0.
- R7: At most one slot differs between the read bucket and the write-back bucket. Every other slot passes through bit for bit.
- R8: The results of a request presented with `in_valid` appear two rising edges later, with `out_valid` set. A request is accepted on every cycle, including back to back.
- R9: `fwd_valid_vec` is the post-operation valid vector. `fwd_match` reports whether a match existed before the operation. `fwd_op` echoes the opcode. `fwd_slot` is the index of the matching slot, or of the slot filled by an insert without a match, and is 0 in all other cases.
- R10: Opcode 2'b11 is a no-operation. The bucket is unchanged, and `wb_en`, `hit` and `full` stay 0.
- R11: While `rst_n` is low, and until the first request completes, `out_valid`, `wb_en`, `hit`, `full` and `fwd_match` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | Opcode: 00 search, 01 insert, 10 delete, 11 no-op |
| in_key | input | KEY_W | Request key |
| in_val | input | VAL_W | Request value (used by insert) |
| rd_keys | input | NUM_SLOTS*KEY_W | Stored keys of the bucket as read |
| rd_vals | input | NUM_SLOTS*VAL_W | Stored values of the bucket as read |
| rd_valid | input | NUM_SLOTS | Valid flags of the bucket as read |
| out_valid | output | 1 | Result outputs hold a completed request |
| wb_en | output | 1 | Bucket image changed and must be written back |
| wb_keys | output | NUM_SLOTS*KEY_W | Write-back keys |
| wb_vals | output | NUM_SLOTS*VAL_W | Write-back values |
| wb_valid | output | NUM_SLOTS | Write-back valid flags |
| hit | output | 1 | Search found the key |
| srch_val | output | VAL_W | Value found by search, 0 on a miss |
| full | output | 1 | Insert dropped because the bucket had no free slot |
| fwd_valid_vec | output | NUM_SLOTS | Post-operation valid vector for forwarding |
| fwd_match | output | 1 | A match existed before the operation |
| fwd_slot | output | IDX_W | Matched or filled slot index |
| fwd_op | output | 2 | Opcode of the completed request |

## Verification
Every output belongs to the request presented two rising edges earlier. The bench therefore drives each request on a falling edge and reads its results on the falling edge that follows the second rising edge. For sequential requests, the bench returns `in_valid` to 0 in the cycle between. The streaming test checks each request against expectations stored two entries back. This confirms that back-to-back requests keep the two-cycle spacing and do not interfere with one another.

// File: rtl/hbe_pkg.sv
package hbe_pkg;
  typedef enum logic [1:0] {
    OP_SEARCH = 2'b00,
    OP_INSERT = 2'b01,
    OP_DELETE = 2'b10,
    OP_NOP    = 2'b11
  } hbe_op_e;
endpackage

// File: rtl/hbe_slot_match.sv
module hbe_slot_match #(
  parameter int NUM_SLOTS = 4,
  parameter int KEY_W     = 8
) (
  input  logic [KEY_W-1:0]           key,
  input  logic [NUM_SLOTS*KEY_W-1:0] slot_keys,
  input  logic [NUM_SLOTS-1:0]       slot_valid,
  output logic [NUM_SLOTS-1:0]       match_vec
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    // An empty slot never matches, whatever key it still holds
    assign match_vec[i] = slot_valid[i] && (slot_keys[i*KEY_W +: KEY_W] == key);
  end
endmodule

// File: rtl/hbe_slot_select.sv
module hbe_slot_select
  import hbe_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  hbe_op_e              op,
  input  logic [NUM_SLOTS-1:0] match_vec,
  input  logic [NUM_SLOTS-1:0] valid_vec,
  output logic [NUM_SLOTS-1:0] sel,
  output logic                 any_match,
  output logic                 free_avail,
  output logic [IDX_W-1:0]     tgt_idx
);
  localparam logic [NUM_SLOTS-1:0] ONE = NUM_SLOTS'(1);

  function automatic logic [NUM_SLOTS-1:0] lowest_set(input logic [NUM_SLOTS-1:0] v);
    return v & (~v + ONE);
  endfunction

  function automatic logic [IDX_W-1:0] to_index(input logic [NUM_SLOTS-1:0] oh);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (oh[i]) idx = idx | IDX_W'(i);
    return idx;
  endfunction

  logic [NUM_SLOTS-1:0] match_oh;
  logic [NUM_SLOTS-1:0] free_oh;
  logic [NUM_SLOTS-1:0] tgt_oh;

  assign match_oh   = lowest_set(match_vec);
  assign free_oh    = lowest_set(~valid_vec);
  assign any_match  = |match_vec;
  assign free_avail = |(~valid_vec);

  always_comb begin
    tgt_oh = '0;
    if (any_match)            tgt_oh = match_oh;
    else if (op == OP_INSERT) tgt_oh = free_oh;
    unique case (op)
      OP_INSERT: sel = tgt_oh;
      OP_DELETE: sel = any_match ? match_oh : '0;
      default:   sel = '0;
    endcase
  end

  assign tgt_idx = to_index(tgt_oh);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R7
  AST_SEL_NEEDS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> (any_match || (op == OP_INSERT && (sel & valid_vec) == '0))); // R4
endmodule

// File: rtl/hbe_slot_pe.sv
module hbe_slot_pe
  import hbe_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter int VAL_W = 8
) (
  input  hbe_op_e          op,
  input  logic             sel,
  input  logic [KEY_W-1:0] in_key,
  input  logic [VAL_W-1:0] in_val,
  input  logic [KEY_W-1:0] old_key,
  input  logic [VAL_W-1:0] old_val,
  input  logic             old_valid,
  output logic [KEY_W-1:0] new_key,
  output logic [VAL_W-1:0] new_val,
  output logic             new_valid
);
  localparam int SLOT_W = KEY_W + VAL_W + 1;

  logic [SLOT_W-1:0] orig_slot, ins_slot, del_slot, upd_slot, out_slot;

  assign orig_slot = {old_valid, old_key, old_val};
  assign ins_slot  = {1'b1, in_key, in_val};
  assign del_slot  = {1'b0, old_key, old_val};

  always_comb begin
    unique case (op)
      OP_INSERT: upd_slot = ins_slot;
      OP_DELETE: upd_slot = del_slot;
      default:   upd_slot = orig_slot;
    endcase
  end

  assign out_slot = sel ? upd_slot : orig_slot;
  assign {new_valid, new_key, new_val} = out_slot;
endmodule

// File: rtl/bucket_update_engine.sv
module bucket_update_engine
  import hbe_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int KEY_W     = 8,
  parameter int VAL_W     = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 in_op,
  input  logic [KEY_W-1:0]           in_key,
  input  logic [VAL_W-1:0]           in_val,
  input  logic [NUM_SLOTS*KEY_W-1:0] rd_keys,
  input  logic [NUM_SLOTS*VAL_W-1:0] rd_vals,
  input  logic [NUM_SLOTS-1:0]       rd_valid,
  output logic                       out_valid,
  output logic                       wb_en,
  output logic [NUM_SLOTS*KEY_W-1:0] wb_keys,
  output logic [NUM_SLOTS*VAL_W-1:0] wb_vals,
  output logic [NUM_SLOTS-1:0]       wb_valid,
  output logic                       hit,
  output logic [VAL_W-1:0]           srch_val,
  output logic                       full,
  output logic [NUM_SLOTS-1:0]       fwd_valid_vec,
  output logic                       fwd_match,
  output logic [IDX_W-1:0]           fwd_slot,
  output logic [1:0]                 fwd_op
);
  // Examine stage: key compare on the bucket as read
  logic [NUM_SLOTS-1:0] cmp_vec;

  hbe_slot_match #(.NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W)) u_match (
    .key(in_key), .slot_keys(rd_keys), .slot_valid(rd_valid), .match_vec(cmp_vec)
  );

  logic                       s1_vld;
  hbe_op_e                    s1_op;
  logic [KEY_W-1:0]           s1_key;
  logic [VAL_W-1:0]           s1_val;
  logic [NUM_SLOTS*KEY_W-1:0] s1_keys;
  logic [NUM_SLOTS*VAL_W-1:0] s1_vals;
  logic [NUM_SLOTS-1:0]       s1_valid;
  logic [NUM_SLOTS-1:0]       s1_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_op    <= OP_NOP;
      s1_key   <= '0;
      s1_val   <= '0;
      s1_keys  <= '0;
      s1_vals  <= '0;
      s1_valid <= '0;
      s1_match <= '0;
    end else begin
      s1_vld   <= in_valid;
      s1_op    <= hbe_op_e'(in_op);
      s1_key   <= in_key;
      s1_val   <= in_val;
      s1_keys  <= rd_keys;
      s1_vals  <= rd_vals;
      s1_valid <= rd_valid;
      s1_match <= cmp_vec;
    end
  end

  // Execute stage: slot selection and per-slot processing elements
  logic [NUM_SLOTS-1:0] sel;
  logic                 any_match;
  logic                 free_avail;
  logic [IDX_W-1:0]     tgt_idx;

  hbe_slot_select #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
    .clk(clk), .rst_n(rst_n), .op(s1_op), .match_vec(s1_match), .valid_vec(s1_valid),
    .sel(sel), .any_match(any_match), .free_avail(free_avail), .tgt_idx(tgt_idx)
  );

  logic [NUM_SLOTS*KEY_W-1:0] nx_keys;
  logic [NUM_SLOTS*VAL_W-1:0] nx_vals;
  logic [NUM_SLOTS-1:0]       nx_valid;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pe
    hbe_slot_pe #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_pe (
      .op(s1_op), .sel(sel[i]), .in_key(s1_key), .in_val(s1_val),
      .old_key(s1_keys[i*KEY_W +: KEY_W]), .old_val(s1_vals[i*VAL_W +: VAL_W]),
      .old_valid(s1_valid[i]),
      .new_key(nx_keys[i*KEY_W +: KEY_W]), .new_val(nx_vals[i*VAL_W +: VAL_W]),
      .new_valid(nx_valid[i])
    );
  end

  // Named execute-stage events
  logic             ev_write;
  logic             ev_hit;
  logic             ev_full;
  logic [VAL_W-1:0] ev_found_val;

  assign ev_write     = s1_vld && (|sel);
  assign ev_hit       = s1_vld && (s1_op == OP_SEARCH) && any_match;
  assign ev_full      = s1_vld && (s1_op == OP_INSERT) && !any_match && !free_avail;
  assign ev_found_val = ev_hit ? s1_vals[tgt_idx*VAL_W +: VAL_W] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      wb_en         <= 1'b0;
      wb_keys       <= '0;
      wb_vals       <= '0;
      wb_valid      <= '0;
      hit           <= 1'b0;
      srch_val      <= '0;
      full          <= 1'b0;
      fwd_valid_vec <= '0;
      fwd_match     <= 1'b0;
      fwd_slot      <= '0;
      fwd_op        <= 2'b11;
    end else begin
      out_valid     <= s1_vld;
      wb_en         <= ev_write;
      wb_keys       <= nx_keys;
      wb_vals       <= nx_vals;
      wb_valid      <= nx_valid;
      hit           <= ev_hit;
      srch_val      <= ev_found_val;
      full          <= ev_full;
      fwd_valid_vec <= nx_valid;
      fwd_match     <= s1_vld && any_match;
      fwd_slot      <= tgt_idx;
      fwd_op        <= s1_op;
    end
  end

  AST_ACCEPT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_vld); // R8
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_valid); // R8
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wb_en); // R5
  AST_HIT_IS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (fwd_op == OP_SEARCH && fwd_match)); // R2
  AST_DELETE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fwd_op == OP_DELETE && fwd_match) |-> !wb_valid[fwd_slot]); // R6
  AST_INSERT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fwd_op == OP_INSERT && !full) |-> (wb_valid[fwd_slot] && wb_en)); // R4
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_op == OP_NOP) |-> (!wb_en && !hit && !full)); // R10
endmodule

// File: tb/bucket_update_engine_test.sv
`timescale 1ns/1ps
module bucket_update_engine_test;
  localparam int NS = 4;
  localparam int KW = 8;
  localparam int VW = 8;
  localparam int IW = 2;
  localparam int NST = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             in_valid = 1'b0;
  logic [1:0]       in_op = 2'b11;
  logic [KW-1:0]    in_key = '0;
  logic [VW-1:0]    in_val = '0;
  logic [NS*KW-1:0] rd_keys = '0;
  logic [NS*VW-1:0] rd_vals = '0;
  logic [NS-1:0]    rd_valid = '0;
  logic             out_valid, wb_en, hit, full, fwd_match;
  logic [NS*KW-1:0] wb_keys;
  logic [NS*VW-1:0] wb_vals;
  logic [NS-1:0]    wb_valid, fwd_valid_vec;
  logic [VW-1:0]    srch_val;
  logic [IW-1:0]    fwd_slot;
  logic [1:0]       fwd_op;

  bucket_update_engine #(.NUM_SLOTS(NS), .KEY_W(KW), .VAL_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_key(in_key),
    .in_val(in_val), .rd_keys(rd_keys), .rd_vals(rd_vals), .rd_valid(rd_valid),
    .out_valid(out_valid), .wb_en(wb_en), .wb_keys(wb_keys), .wb_vals(wb_vals),
    .wb_valid(wb_valid), .hit(hit), .srch_val(srch_val), .full(full),
    .fwd_valid_vec(fwd_valid_vec), .fwd_match(fwd_match), .fwd_slot(fwd_slot),
    .fwd_op(fwd_op)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [KW-1:0] m_key [NS];
  logic [VW-1:0] m_val [NS];
  logic          m_vld [NS];

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NS; i++) begin
      m_key[i] = '0; m_val[i] = '0; m_vld[i] = 1'b0;
    end
  endtask

  // One request: drive at a falling edge, read results two rising edges later
  task automatic run_op(input logic [1:0] op, input logic [KW-1:0] k,
                        input logic [VW-1:0] v, input string tag);
    int mi, fi;
    logic [KW-1:0] ek [NS];
    logic [VW-1:0] ev [NS];
    logic          el [NS];
    logic [NS*KW-1:0] xk;
    logic [NS*VW-1:0] xv;
    logic [NS-1:0]    xl;
    logic e_wb, e_hit, e_full;
    logic [VW-1:0] e_sv;
    int e_slot;
    mi = -1; fi = -1;
    for (int i = NS - 1; i >= 0; i--) begin
      if (m_vld[i] && m_key[i] == k) mi = i;
      if (!m_vld[i]) fi = i;
    end
    for (int i = 0; i < NS; i++) begin
      ek[i] = m_key[i]; ev[i] = m_val[i]; el[i] = m_vld[i];
    end
    e_wb = 0; e_hit = 0; e_full = 0; e_sv = '0; e_slot = (mi >= 0) ? mi : 0;
    case (op)
      2'b00: if (mi >= 0) begin e_hit = 1; e_sv = m_val[mi]; end
      2'b01: begin
        if (mi >= 0) begin ev[mi] = v; e_wb = 1; end
        else if (fi >= 0) begin ek[fi] = k; ev[fi] = v; el[fi] = 1; e_wb = 1; e_slot = fi; end
        else e_full = 1;
      end
      2'b10: if (mi >= 0) begin el[mi] = 0; e_wb = 1; end
      default: ;
    endcase
    for (int i = 0; i < NS; i++) begin
      xk[i*KW +: KW] = ek[i]; xv[i*VW +: VW] = ev[i]; xl[i] = el[i];
    end
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_key = k; in_val = v;
    for (int i = 0; i < NS; i++) begin
      rd_keys[i*KW +: KW] = m_key[i];
      rd_vals[i*VW +: VW] = m_val[i];
      rd_valid[i]         = m_vld[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8", "out_valid", 64'(out_valid), 64'(1));
    chk(tag, "wb_en", 64'(wb_en), 64'(e_wb));
    chk(tag, "hit", 64'(hit), 64'(e_hit));
    chk(tag, "srch_val", 64'(srch_val), 64'(e_sv));
    chk(tag, "full", 64'(full), 64'(e_full));
    chk(tag, "wb_keys", 64'(wb_keys), 64'(xk));
    chk(tag, "wb_vals", 64'(wb_vals), 64'(xv));
    chk(tag, "wb_valid", 64'(wb_valid), 64'(xl));
    chk("R9", "fwd_valid_vec", 64'(fwd_valid_vec), 64'(xl));
    chk("R9", "fwd_match", 64'(fwd_match), 64'(mi >= 0));
    chk("R9", "fwd_slot", 64'(fwd_slot), 64'(e_slot));
    chk("R9", "fwd_op", 64'(fwd_op), 64'(op));
    for (int i = 0; i < NS; i++) begin
      m_key[i] = ek[i]; m_val[i] = ev[i]; m_vld[i] = el[i];
    end
  endtask

  logic       exp_h [NST];
  logic [7:0] exp_v [NST];

  initial begin
    int seed;
    logic [1:0] op;
    string tag;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "out_valid in reset", 64'(out_valid), 64'(0));
    chk("R11", "wb_en in reset", 64'(wb_en), 64'(0));
    chk("R11", "hit in reset", 64'(hit), 64'(0));
    chk("R11", "full in reset", 64'(full), 64'(0));
    chk("R11", "fwd_match in reset", 64'(fwd_match), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "out_valid idle", 64'(out_valid), 64'(0));

    // Directed cases
    run_op(2'b00, 8'd5, 8'h00, "R2");   // search miss on empty bucket
    run_op(2'b01, 8'd5, 8'h11, "R4");   // fills slot 0
    run_op(2'b01, 8'd7, 8'h22, "R4");   // fills slot 1
    run_op(2'b00, 8'd7, 8'h00, "R2");   // hit
    run_op(2'b01, 8'd5, 8'h33, "R3");   // overwrite value in slot 0
    run_op(2'b10, 8'd5, 8'h00, "R6");   // delete slot 0
    run_op(2'b00, 8'd5, 8'h00, "R2");   // miss after delete
    run_op(2'b01, 8'd9, 8'h44, "R4");   // lowest free is slot 0 again
    run_op(2'b01, 8'd10, 8'h55, "R4");
    run_op(2'b01, 8'd11, 8'h66, "R4");  // bucket now full
    run_op(2'b01, 8'd12, 8'h77, "R5");  // dropped
    run_op(2'b01, 8'd10, 8'h88, "R3");  // overwrite still allowed when full
    run_op(2'b10, 8'd99, 8'h00, "R6");  // delete miss
    run_op(2'b11, 8'd9, 8'hAA, "R10");  // no-op on a matching key
    run_op(2'b10, 8'd11, 8'h00, "R7");  // only slot 3 changes

    // Duplicate keys and a stale key in an empty slot: lowest valid match wins
    clear_model();
    m_key[0] = 8'd7; m_val[0] = 8'hE0; m_vld[0] = 1'b0;
    m_key[1] = 8'd7; m_val[1] = 8'hE1; m_vld[1] = 1'b1;
    m_key[2] = 8'd7; m_val[2] = 8'hE2; m_vld[2] = 1'b1;
    m_key[3] = 8'd3; m_val[3] = 8'hE3; m_vld[3] = 1'b1;
    run_op(2'b00, 8'd7, 8'h00, "R1");
    run_op(2'b01, 8'd7, 8'h5A, "R1");
    run_op(2'b10, 8'd7, 8'h00, "R1");

    // Sweep over a small key space
    clear_model();
    seed = 17;
    for (int it = 0; it < 2000; it++) begin
      seed = seed * 1103515245 + 12345;
      op = seed[17:16];
      tag = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R4" : (op == 2'b10) ? "R6" : "R10";
      run_op(op, 8'(seed[26:24] % 6), 8'(it), tag);
    end

    // Back-to-back searches, each with its own bucket image (R8)
    for (int c = 0; c < NST + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        chk("R8", "stream out_valid", 64'(out_valid), 64'(1));
        chk("R8", "stream hit", 64'(hit), 64'(exp_h[c-2]));
        chk("R8", "stream srch_val", 64'(srch_val), 64'(exp_v[c-2]));
      end
      if (c < NST) begin
        in_valid = 1'b1; in_op = 2'b00; in_val = '0;
        for (int j = 0; j < NS; j++) begin
          rd_keys[j*KW +: KW] = 8'(c * 4 + j);
          rd_vals[j*VW +: VW] = {4'(c), 4'(j)};
          rd_valid[j]         = 1'b1;
        end
        if (c % 2 == 0) begin
          in_key = 8'(c * 4 + (c / 2) % 4);
          exp_h[c] = 1'b1;
          exp_v[c] = {4'(c), 4'((c / 2) % 4)};
        end else begin
          in_key = 8'hFF;
          exp_h[c] = 1'b0;
          exp_v[c] = 8'h00;
        end
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8", "stream drained", 64'(out_valid), 64'(0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule